// File: doc/BRIEF.md
# NAND Target Command Responder

This block stands on the target side of an 8-bit asynchronous NAND flash bus. All host strobes (chip enable, command and address latch enables, write and read strobes, write protect) and the inbound byte pass through two-flop synchronizers on a system clock. Edges are then found on the synchronized copies. A rising write strobe latches the byte as a command or as an address. A falling read strobe makes the block present the next byte of the active data-out mode and step a column counter.

Four operations are answered. The first is device identification: five fixed bytes. The second is the parameter page: 256 bytes from a block-RAM style table, followed by two identical copies, then FFh filler. The third is a status byte that repeats on every read strobe. The fourth is a reset, which drops the block to idle and holds the ready/busy flag low for a programmable number of clocks. A data-out mode is entered only when the address byte is exactly 00h. It stays active until the next command. After identification, a status request counts only once a dummy 00h command has been given. The memory array, program and erase, ECC and analog timing are not modelled.

Top module: `nand_cmd_responder`

## Requirements
- R1: While chip enable is low, a rising write strobe with command-latch high and address-latch low latches the byte as a command. With address-latch high and command-latch low, the byte is latched as an address.
- R2: While chip enable is high, `io_oe` stays 0 and no command or address is latched; a reset command issued then leaves `rb_n` at 1.
- R3: Command 90h followed by address 00h enters identification mode. Successive read strobes return 01h, DCh, 90h, 95h, 54h, and 00h for every read after the fifth.
- R4: After 90h or ECh, an address byte other than 00h returns the block to idle, and a read strobe then leaves `io_oe` at 0.
- R5: Command ECh followed by address 00h enters parameter-page mode. Bytes 0 to 3 are 4Fh, 4Eh, 46h, 49h. Bytes 254 and 255 hold, low byte first, a CRC-16 over bytes 0 to 253 (polynomial 8005h, initial value 4F4Eh, most significant bit first, no reflection).
- R6: In parameter-page mode, bytes 256 to 767 repeat bytes 0 to 255 twice, and every byte from 768 on reads FFh.
- R7: A data-out mode stays active, and its column keeps counting, across address bytes and chip-enable pauses, until the next command is latched.
- R8: Once identification mode has been entered, command 70h does not start a status read (`io_oe` stays 0) until a 00h command or a reset command has been latched.
- R9: Command 70h selects status. The status byte has bit 7 equal to the write-protect input (1 = writable), bit 6 = 1 when not busy, bit 0 = fail flag, and all other bits 0. The same byte is returned on every read strobe.
- R10: A program command (80h) or erase command (60h) latched while write-protect is low is rejected and sets the fail flag. The fail flag stays set until a reset command is latched. With write-protect high, these commands leave the fail flag unchanged.
- R11: Command FFh returns the block to idle and clears the column. It drives `rb_n` to 0 for BUSY_CYCLES clocks. While busy, only 70h and FFh are accepted and all other commands and addresses are ignored.
- R12: When a write-strobe rise and a read-strobe fall are seen in the same clock, the write side is processed and the read edge is discarded: the output byte and the column do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low, latches on its rising edge |
| re_n | input | 1 | Read strobe, active low, serves a byte on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Inbound byte from the bus |
| io_out | output | 8 | Outbound byte |
| io_oe | output | 1 | Output enable for the bus driver |
| rb_n | output | 1 | Ready (1) / busy (0) flag |

## Verification
A rising write strobe and a falling read strobe can land in the same synchronized clock. Their handling then collides on the column counter and the output register. The bench provokes this in identification mode: it holds an address byte with the write strobe low, then releases the write strobe and drops the read strobe in the same time step. Both edges pass through identical synchronizer depths. The result is judged at the ports: the byte on the bus must remain the one served before, and the next normal read must return the ID byte that follows it. This shows the ignored address did not disturb the mode and the collided read edge did not move the column.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_ID_ARM,
    MD_PG_ARM,
    MD_ID_OUT,
    MD_PG_OUT,
    MD_STAT
  } resp_mode_t;

  localparam logic [7:0] OP_IDENT = 8'h90;
  localparam logic [7:0] OP_PAGE  = 8'hEC;
  localparam logic [7:0] OP_STAT  = 8'h70;
  localparam logic [7:0] OP_DUMMY = 8'h00;
  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] OP_PROG  = 8'h80;
  localparam logic [7:0] OP_ERASE = 8'h60;

  localparam int          ID_LEN   = 5;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_SEED = 16'h4F4E;

  localparam logic [95:0]  VENDOR_TXT = "OPENRESPNDR ";
  localparam logic [159:0] MODEL_TXT  = "NANDTARGET8G        ";

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h01;
      3'd1:    return 8'hDC;
      3'd2:    return 8'h90;
      3'd3:    return 8'h95;
      3'd4:    return 8'h54;
      default: return 8'h00;
    endcase
  endfunction

  // parameter page content without the trailing checksum
  function automatic logic [7:0] page_base(input int unsigned a);
    if (a >= 32 && a < 44) return VENDOR_TXT[8*(43-a) +: 8];
    if (a >= 44 && a < 64) return MODEL_TXT[8*(63-a) +: 8];
    case (a)
      0: return 8'h4F;   1: return 8'h4E;   2: return 8'h46;   3: return 8'h49;
      4: return 8'h02;   6: return 8'h1E;   8: return 8'h1B;   64: return 8'h01;
      81: return 8'h08;  84: return 8'h40;  88: return 8'h02;  90: return 8'h10;
      92: return 8'h40;  97: return 8'h10;  100: return 8'h02; 101: return 8'h23;
      102: return 8'h01; 103: return 8'h50; 105: return 8'h01; 106: return 8'h05;
      107: return 8'h01; 108: return 8'h01; 109: return 8'h03; 110: return 8'h04;
      112: return 8'h01; 113: return 8'h01; 114: return 8'h04; 128: return 8'h0A;
      129: return 8'h1F; 131: return 8'h1F; 133: return 8'hBC; 134: return 8'h02;
      135: return 8'h10; 136: return 8'h27; 137: return 8'h19; 139: return 8'h64;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/nand_page_rom.sv
module nand_page_rom
  import nand_resp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    logic [15:0] crc;
    crc = CRC_SEED;
    for (int i = 0; i < DEPTH - 2; i++) begin
      mem[i] = page_base(i);
      crc    = crc_step(crc, page_base(i));
    end
    mem[DEPTH-2] = crc[7:0];
    mem[DEPTH-1] = crc[15:8];
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_resp_pkg::*;
#(
  parameter int COL_W       = 12,
  parameter int PG_AW       = 8,
  parameter int PAGE_COPIES = 3,
  parameter int BUSY_CYCLES = 20,
  parameter int BUSY_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n_s,
  input  logic             cle_s,
  input  logic             ale_s,
  input  logic             we_n_s,
  input  logic             re_n_s,
  input  logic             wp_n_s,
  input  logic [7:0]       din_s,
  input  logic [7:0]       rom_q,
  output logic [PG_AW-1:0] rom_addr,
  output logic [7:0]       dout,
  output logic             oe,
  output logic             rb_n,
  output resp_mode_t       mode_o,
  output logic [COL_W-1:0] col_o,
  output logic             cmd_ev_o,
  output logic             rd_ev_o
);
  localparam int         PG_END  = PAGE_COPIES << PG_AW;
  localparam logic [COL_W-1:0] COL_MAX = '1;
  localparam logic [BUSY_W-1:0] BUSY_LD = BUSY_W'(BUSY_CYCLES);

  resp_mode_t        mode_q;
  logic [COL_W-1:0]  col_q;
  logic [BUSY_W-1:0] busy_q, busy_nxt;
  logic              we_prev_q, re_prev_q;
  logic              after_id_q, fail_q;
  logic              wr_ev, cmd_ev, adr_ev, rd_ev, busy, cmd_ok, reset_cmd;
  logic              out_mode;
  logic [7:0]        status_byte;

  assign wr_ev     = ~ce_n_s & we_n_s & ~we_prev_q;
  assign cmd_ev    = wr_ev & cle_s & ~ale_s;
  assign adr_ev    = wr_ev & ale_s & ~cle_s;
  assign rd_ev     = ~ce_n_s & ~re_n_s & re_prev_q & ~wr_ev;
  assign busy      = (busy_q != '0);
  assign cmd_ok    = cmd_ev & (~busy | din_s == OP_STAT | din_s == OP_RESET);
  assign reset_cmd = cmd_ok & (din_s == OP_RESET);
  assign out_mode  = (mode_q == MD_ID_OUT) | (mode_q == MD_PG_OUT) | (mode_q == MD_STAT);
  assign status_byte = {wp_n_s, ~busy, 5'b0, fail_q};
  assign rom_addr  = col_q[PG_AW-1:0];

  always_comb begin
    busy_nxt = busy_q;
    if (reset_cmd)  busy_nxt = BUSY_LD;
    else if (busy)  busy_nxt = busy_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev_q <= 1'b1;
      re_prev_q <= 1'b1;
      mode_q    <= MD_IDLE;
      col_q     <= '0;
      busy_q    <= '0;
      after_id_q <= 1'b0;
      fail_q    <= 1'b0;
      dout      <= 8'h00;
      oe        <= 1'b0;
      rb_n      <= 1'b1;
    end else begin
      we_prev_q <= we_n_s;
      re_prev_q <= re_n_s;
      busy_q    <= busy_nxt;
      rb_n      <= (busy_nxt == '0);
      oe        <= ~ce_n_s & ~re_n_s & out_mode;

      if (cmd_ok) begin
        case (din_s)
          OP_RESET: begin
            mode_q     <= MD_IDLE;
            col_q      <= '0;
            after_id_q <= 1'b0;
            fail_q     <= 1'b0;
          end
          OP_IDENT: begin
            mode_q <= MD_ID_ARM;
            col_q  <= '0;
          end
          OP_PAGE: begin
            mode_q <= MD_PG_ARM;
            col_q  <= '0;
          end
          OP_STAT:  mode_q <= after_id_q ? MD_IDLE : MD_STAT;
          OP_DUMMY: begin
            mode_q     <= MD_IDLE;
            after_id_q <= 1'b0;
          end
          OP_PROG, OP_ERASE: begin
            mode_q <= MD_IDLE;
            if (!wp_n_s) fail_q <= 1'b1;
          end
          default: mode_q <= MD_IDLE;
        endcase
      end else if (adr_ev && !busy) begin
        if (mode_q == MD_ID_ARM) begin
          col_q <= '0;
          if (din_s == 8'h00) begin
            mode_q     <= MD_ID_OUT;
            after_id_q <= 1'b1;
          end else begin
            mode_q <= MD_IDLE;
          end
        end else if (mode_q == MD_PG_ARM) begin
          col_q  <= '0;
          mode_q <= (din_s == 8'h00) ? MD_PG_OUT : MD_IDLE;
        end
      end else if (rd_ev) begin
        case (mode_q)
          MD_ID_OUT: begin
            dout <= (col_q < COL_W'(ID_LEN)) ? id_byte(col_q[2:0]) : 8'h00;
            if (col_q != COL_MAX) col_q <= col_q + 1'b1;
          end
          MD_PG_OUT: begin
            dout <= (int'(col_q) < PG_END) ? rom_q : 8'hFF;
            if (col_q != COL_MAX) col_q <= col_q + 1'b1;
          end
          MD_STAT: dout <= status_byte;
          default: ;
        endcase
      end
    end
  end

  assign mode_o   = mode_q;
  assign col_o    = col_q;
  assign cmd_ev_o = cmd_ev;
  assign rd_ev_o  = rd_ev;
endmodule

// File: rtl/nand_cmd_responder.sv
module nand_cmd_responder
  import nand_resp_pkg::*;
#(
  parameter int COL_W       = 12,
  parameter int PG_AW       = 8,
  parameter int PAGE_COPIES = 3,
  parameter int BUSY_CYCLES = 20,
  parameter int BUSY_W      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n
);
  localparam int SYNC_W = 14;
  localparam logic [SYNC_W-1:0] SYNC_RST = {6'b100111, 8'h00};

  logic [SYNC_W-1:0] sync_q;
  logic              ce_n_s, cle_s, ale_s, we_n_s, re_n_s, wp_n_s;
  logic [7:0]        din_s, rom_q;
  logic [PG_AW-1:0]  rom_addr;
  resp_mode_t        mode;
  logic [COL_W-1:0]  col;
  logic              cmd_ev, rd_ev;

  nand_strobe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce_n, cle, ale, we_n, re_n, wp_n, io_in}),
    .q   (sync_q)
  );

  assign {ce_n_s, cle_s, ale_s, we_n_s, re_n_s, wp_n_s, din_s} = sync_q;

  nand_page_rom #(.AW(PG_AW)) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .q    (rom_q)
  );

  nand_cmd_ctrl #(
    .COL_W(COL_W), .PG_AW(PG_AW), .PAGE_COPIES(PAGE_COPIES),
    .BUSY_CYCLES(BUSY_CYCLES), .BUSY_W(BUSY_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ce_n_s   (ce_n_s),
    .cle_s    (cle_s),
    .ale_s    (ale_s),
    .we_n_s   (we_n_s),
    .re_n_s   (re_n_s),
    .wp_n_s   (wp_n_s),
    .din_s    (din_s),
    .rom_q    (rom_q),
    .rom_addr (rom_addr),
    .dout     (io_out),
    .oe       (io_oe),
    .rb_n     (rb_n),
    .mode_o   (mode),
    .col_o    (col),
    .cmd_ev_o (cmd_ev),
    .rd_ev_o  (rd_ev)
  );
endmodule

// File: rtl/nand_resp_chk.sv
module nand_resp_chk
  import nand_resp_pkg::*;
#(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             io_oe,
  input logic             rb_n,
  input logic             ce_n_s,
  input logic [7:0]       din_s,
  input logic             cmd_ev,
  input logic             rd_ev,
  input resp_mode_t       mode,
  input logic [COL_W-1:0] col
);
  // R2
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    io_oe |-> $past(!ce_n_s));

  // R2
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n_s |=> $stable(mode));

  // R11
  reset_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && din_s == 8'hFF) |=> !rb_n);

  // R7
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && (mode == MD_ID_OUT || mode == MD_PG_OUT) && col != '1)
      |=> col == $past(col) + 1'b1);

  // R9
  status_col_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && mode == MD_STAT) |=> $stable(col));
endmodule

bind nand_cmd_responder nand_resp_chk #(.COL_W(COL_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .io_oe  (io_oe),
  .rb_n   (rb_n),
  .ce_n_s (ce_n_s),
  .din_s  (din_s),
  .cmd_ev (cmd_ev),
  .rd_ev  (rd_ev),
  .mode   (mode),
  .col    (col)
);

// File: tb/sim_nand_cmd_responder.sv
module sim_nand_cmd_responder;
  localparam int BUSY = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic       io_oe, rb_n;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  logic [7:0] exp_q[$];
  logic       oe_q[$];
  string      tag_q[$];
  event       smp;
  logic [7:0] pg [256];

  always #10 clk = ~clk;

  nand_cmd_responder #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit is_cmd, input logic [7:0] b);
    cle = is_cmd; ale = ~is_cmd; io_in = b;
    tick(4); we_n = 1'b0;
    tick(4); we_n = 1'b1;
    tick(4); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); bus_wr(1'b1, b); endtask
  task automatic adr(input logic [7:0] b); bus_wr(1'b0, b); endtask

  // driver: push expectation, pulse the read strobe, hand sampling to the monitor
  task automatic rd_exp(input logic [7:0] e, input logic oe, input string tag);
    exp_q.push_back(e); oe_q.push_back(oe); tag_q.push_back(tag);
    re_n = 1'b0; tick(6); -> smp; tick(1);
    re_n = 1'b1; tick(5);
  endtask

  task automatic rd_raw(output logic [7:0] v);
    re_n = 1'b0; tick(6); v = io_out;
    re_n = 1'b1; tick(5);
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h4F4E;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ pg[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  // monitor: pops expectations as outputs are sampled
  initial forever begin
    @(smp);
    begin
      logic [7:0] e; logic o; string t;
      e = exp_q.pop_front(); o = oe_q.pop_front(); t = tag_q.pop_front();
      n_chk++;
      if (io_oe !== o || (o && io_out !== e)) begin
        n_bad++;
        $display("FAIL %s: actual oe=%0b data=%0h expected oe=%0b data=%0h", t, io_oe, io_out, o, e);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [15:0] crc;
    tick(5); rst = 1'b0; tick(5);
    check(io_oe === 1'b0, "R2 reset oe", io_oe, 0);
    check(rb_n === 1'b1, "R11 reset rb_n", rb_n, 1);
    ce_n = 1'b0; tick(4);

    // R1 R3 identification
    cmd(8'h90); adr(8'h00);
    rd_exp(8'h01, 1'b1, "R3 id0");
    rd_exp(8'hDC, 1'b1, "R3 id1");
    // R12 address rise and read fall collide; read edge dropped, R7 mode kept
    ale = 1'b1; io_in = 8'h00; tick(4); we_n = 1'b0; tick(4);
    exp_q.push_back(8'hDC); oe_q.push_back(1'b1); tag_q.push_back("R12 collide");
    we_n = 1'b1; re_n = 1'b0; tick(6); -> smp; tick(1);
    re_n = 1'b1; ale = 1'b0; tick(5);
    rd_exp(8'h90, 1'b1, "R12 next id2");
    rd_exp(8'h95, 1'b1, "R3 id3");
    rd_exp(8'h54, 1'b1, "R3 id4");
    rd_exp(8'h00, 1'b1, "R3 past id");

    // R2 deselected: no output, reset ignored
    ce_n = 1'b1; tick(4);
    cmd(8'hFF); tick(4);
    check(rb_n === 1'b1, "R2 deselect no latch", rb_n, 1);
    rd_exp(8'h00, 1'b0, "R2 deselect oe");
    ce_n = 1'b0; tick(4);
    rd_exp(8'h00, 1'b1, "R7 mode persists");

    // R8 status after identification
    cmd(8'h70);
    rd_exp(8'h00, 1'b0, "R8 status blocked");
    cmd(8'h00); cmd(8'h70);
    rd_exp(8'hC0, 1'b1, "R8 status after dummy");
    rd_exp(8'hC0, 1'b1, "R9 status repeats");

    // R10 write protect
    wp_n = 1'b0; tick(4);
    cmd(8'h80); cmd(8'h70);
    rd_exp(8'h41, 1'b1, "R10 wp reject");
    wp_n = 1'b1; tick(4);
    cmd(8'h60); cmd(8'h70);
    rd_exp(8'hC1, 1'b1, "R10 fail sticky");

    // R11 reset busy window
    cmd(8'hFF);
    check(rb_n === 1'b0, "R11 busy", rb_n, 0);
    cmd(8'h70);
    rd_exp(8'h80, 1'b1, "R11 status busy");
    cmd(8'h90); adr(8'h00);
    rd_exp(8'h80, 1'b1, "R11 cmd ignored busy");
    tick(BUSY + 20);
    check(rb_n === 1'b1, "R11 ready", rb_n, 1);
    rd_exp(8'hC0, 1'b1, "R9 ready status");

    // R4 non-zero address
    cmd(8'h90); adr(8'h01);
    rd_exp(8'h00, 1'b0, "R4 id bad addr");
    cmd(8'hEC); adr(8'h20);
    rd_exp(8'h00, 1'b0, "R4 page bad addr");

    // R5 R6 parameter page
    cmd(8'hEC); adr(8'h00);
    for (int i = 0; i < 256; i++) begin
      rd_raw(v); pg[i] = v;
    end
    check(pg[0] == 8'h4F, "R5 sig0", pg[0], 8'h4F);
    check(pg[1] == 8'h4E, "R5 sig1", pg[1], 8'h4E);
    check(pg[2] == 8'h46, "R5 sig2", pg[2], 8'h46);
    check(pg[3] == 8'h49, "R5 sig3", pg[3], 8'h49);
    crc = ref_crc(254);
    check({pg[255], pg[254]} == crc, "R5 crc", {pg[255], pg[254]}, crc);
    for (int i = 256; i < 768; i++) rd_exp(pg[i % 256], 1'b1, "R6 copy");
    rd_exp(8'hFF, 1'b1, "R6 fill768");
    rd_exp(8'hFF, 1'b1, "R6 fill769");

    // R11 column cleared, identification restarts at first byte
    cmd(8'hFF); tick(BUSY + 20);
    cmd(8'h90); adr(8'h00);
    rd_exp(8'h01, 1'b1, "R11 col cleared");
    tick(10);
    finish_run();
  end
endmodule